// File: doc/BRIEF.md
# Receiver Power-Up and Calibration Sequencer

This block runs on the host side and takes an FM receiver front end from reset to a calibrated, running state. When started, it issues a fixed, ordered series of register write requests to a serial master. Between certain writes it waits out settling intervals, each given as a clock-cycle count. It does not start until the local-oscillator source reports that it is running.

A supply-range input chooses between two paths. On the direct-supply path the block sets the full-run mode, waits for the reference circuits, fires the discriminator calibration trigger, and waits for calibration and then for discriminator settling. On the regulator path it first sets the standby mode that powers the reference. It then pulses the regulator status bit low and back high together with the regulator enable. It waits for the analog ground to settle and then follows the direct-supply steps. The sequencer keeps a shadow copy of both control registers, so each write changes only the field it targets.

Top module: `rxcal_seq`

## Requirements
- R1: While rst_ni is low and after it rises, wr_valid_o, busy_o and done_o are 0 and no write is issued.
- R2: A start_i pulse is accepted only while the sequencer is idle and lo_ready_i is 1. A start_i pulse with lo_ready_i at 0, or one that arrives while a sequence runs, issues no write and produces no extra done_o pulse.
- R3: With ldo_path_i=1 the writes are {addr,data}: (0x01,0x86), (0x01,0x06), (0x01,0xC6), (0x01,0xC7), (0x02,0x05). Register 0x01 layout: bit7 regulator status, bit6 regulator enable, bits5:4 filter width, bits3:2 LO select, bits1:0 mode (10 standby-reference, 11 full run). Its reset value is 0x85. Register 0x02 has the calibration trigger at bit0 and reset value 0x04.
- R4: With ldo_path_i=0 the writes are (0x01, shadow with mode 11) followed by (0x02, shadow with bit0 set). From reset these are (0x01,0x87) and (0x02,0x05).
- R5: Each write to 0x01 keeps all fields other than the targeted one at their shadow values. After a regulator-path run, a direct-path run writes (0x01,0xC7) first.
- R6: wr_addr_o and wr_data_o stay stable while wr_valid_o is 1 and wr_ack_i is 0. A write is taken on a cycle where both are 1, and the next write is presented only after that.
- R7: After the regulator-enable write is taken, wr_valid_o stays low for exactly AGND_CYC cycles before the next write is presented.
- R8: After the full-run mode write is taken, wr_valid_o stays low for exactly MODE_CYC cycles before the calibration write is presented.
- R9: After the calibration write is taken, done_o rises after exactly CAL_CYC+SETTLE_CYC cycles and is high for a single cycle.
- R10: busy_o is 1 from the cycle after an accepted start until done_o, and 0 while done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the sequence |
| lo_ready_i | input | 1 | LO source running; qualifies start |
| ldo_path_i | input | 1 | 1 selects the regulator path, 0 the direct-supply path |
| wr_ack_i | input | 1 | Serial master has taken the current write |
| wr_valid_o | output | 1 | Write request pending |
| wr_addr_o | output | 6 | Register address of the write |
| wr_data_o | output | 8 | Register data of the write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the final settling wait |

## Verification
A wrong step index or a corrupt shadow shows at the ports on the very next write, as a wrong address or data byte. The bench compares every byte against a table. A miscounted wait shows up as a gap between a taken write and the next wr_valid_o rise, or before the done_o pulse, that is off by at least one cycle. Gaps are measured to the exact cycle. The bench exposes shadow retention by running a second sequence without a reset, and it exposes a leaky start gate through the write log and the done count.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;
  localparam int STEP_W   = 4;
  localparam int STEP_REG = 0;
  localparam int STEP_DIR = 4;

  localparam logic [5:0] ADDR_CTL1 = 6'h01;
  localparam logic [5:0] ADDR_CTL2 = 6'h02;
  localparam int BIT_LDO_STAT = 7;
  localparam int BIT_LDO_EN   = 6;
  localparam int BIT_CAL      = 0;

  typedef enum logic [1:0] {K_WRITE, K_WAIT, K_END} kind_e;
  typedef enum logic [2:0] {W_MODE_STBY, W_LDO_LOW, W_LDO_ON, W_MODE_RUN, W_CAL} wkind_e;
  typedef enum logic [1:0] {T_AGND, T_MODE, T_CAL, T_SETTLE} tsel_e;

  typedef struct packed {
    kind_e  kind;
    wkind_e wk;
    tsel_e  ts;
  } step_t;
endpackage

// File: rtl/rxcal_step_rom.sv
module rxcal_step_rom
  import rxcal_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output step_t             op_o
);
  always_comb begin
    op_o = '{kind: K_END, wk: W_CAL, ts: T_SETTLE};
    unique case (step_i)
      4'd0: op_o = '{kind: K_WRITE, wk: W_MODE_STBY, ts: T_AGND};
      4'd1: op_o = '{kind: K_WRITE, wk: W_LDO_LOW,   ts: T_AGND};
      4'd2: op_o = '{kind: K_WRITE, wk: W_LDO_ON,    ts: T_AGND};
      4'd3: op_o = '{kind: K_WAIT,  wk: W_CAL,       ts: T_AGND};
      4'd4: op_o = '{kind: K_WRITE, wk: W_MODE_RUN,  ts: T_MODE};
      4'd5: op_o = '{kind: K_WAIT,  wk: W_CAL,       ts: T_MODE};
      4'd6: op_o = '{kind: K_WRITE, wk: W_CAL,       ts: T_CAL};
      4'd7: op_o = '{kind: K_WAIT,  wk: W_CAL,       ts: T_CAL};
      4'd8: op_o = '{kind: K_WAIT,  wk: W_CAL,       ts: T_SETTLE};
      default: ;
    endcase
  end
endmodule

// File: rtl/rxcal_wait_timer.sv
module rxcal_wait_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // a zero-length wait would never expire
  assert_load_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> load_val_i != '0);
  assert_expire_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !load_i) |=> !expire_o);
endmodule

// File: rtl/rxcal_seq.sv
module rxcal_seq
  import rxcal_pkg::*;
#(
  parameter int         MODE_CYC   = 50000,
  parameter int         CAL_CYC    = 130000,
  parameter int         SETTLE_CYC = 150000,
  parameter int         AGND_CYC   = 13000000,
  parameter logic [7:0] CTL1_RST   = 8'h85,
  parameter logic [7:0] CTL2_RST   = 8'h04
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       lo_ready_i,
  input  logic       ldo_path_i,
  input  logic       wr_ack_i,
  output logic       wr_valid_o,
  output logic [5:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int MAX_AB  = (AGND_CYC > MODE_CYC) ? AGND_CYC : MODE_CYC;
  localparam int MAX_CD  = (CAL_CYC > SETTLE_CYC) ? CAL_CYC : SETTLE_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_WAIT, ST_DONE} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        sh1_q, sh2_q;
  step_t             cur_op, nxt_op;
  logic              expire, load, advance, accept, go;
  logic [CNT_W-1:0]  load_val;

  rxcal_step_rom u_rom_cur (.step_i(step_q),        .op_o(cur_op));
  rxcal_step_rom u_rom_nxt (.step_i(step_q + 1'b1), .op_o(nxt_op));

  assign go      = (state_q == ST_IDLE) && start_i && lo_ready_i;
  assign accept  = (state_q == ST_WRITE) && wr_ack_i;
  assign advance = accept || ((state_q == ST_WAIT) && expire);
  assign load    = advance && (nxt_op.kind == K_WAIT);

  always_comb begin
    unique case (nxt_op.ts)
      T_AGND:  load_val = CNT_W'(AGND_CYC);
      T_MODE:  load_val = CNT_W'(MODE_CYC);
      T_CAL:   load_val = CNT_W'(CAL_CYC);
      default: load_val = CNT_W'(SETTLE_CYC);
    endcase
  end

  rxcal_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .load_val_i(load_val), .expire_o(expire)
  );

  always_comb begin
    wr_addr_o = ADDR_CTL1;
    wr_data_o = sh1_q;
    unique case (cur_op.wk)
      W_MODE_STBY: wr_data_o = {sh1_q[7:2], 2'b10};
      W_LDO_LOW:   wr_data_o[BIT_LDO_STAT] = 1'b0;
      W_LDO_ON: begin
        wr_data_o[BIT_LDO_STAT] = 1'b1;
        wr_data_o[BIT_LDO_EN]   = 1'b1;
      end
      W_MODE_RUN:  wr_data_o = {sh1_q[7:2], 2'b11};
      default: begin
        wr_addr_o = ADDR_CTL2;
        wr_data_o = sh2_q;
        wr_data_o[BIT_CAL] = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      sh1_q   <= CTL1_RST;
      sh2_q   <= CTL2_RST;
    end else begin
      // trigger bit self-clears in the receiver, so shadow keeps it at 0
      if (accept && wr_addr_o == ADDR_CTL1) sh1_q <= wr_data_o;
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_WRITE;
          step_q  <= ldo_path_i ? STEP_W'(STEP_REG) : STEP_W'(STEP_DIR);
        end
        ST_WRITE, ST_WAIT: if (advance) begin
          step_q <= step_q + 1'b1;
          unique case (nxt_op.kind)
            K_WRITE: state_q <= ST_WRITE;
            K_WAIT:  state_q <= ST_WAIT;
            default: state_q <= ST_DONE;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (state_q == ST_WRITE);
  assign busy_o     = (state_q == ST_WRITE) || (state_q == ST_WAIT);
  assign done_o     = (state_q == ST_DONE);

  assert_idle_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(start_i && lo_ready_i)) |=> !busy_o);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ack_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  assert_cal_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o == ADDR_CTL2) |-> wr_data_o[BIT_CAL]);
  assert_keep_fields_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o == ADDR_CTL1) |-> wr_data_o[5:2] == CTL1_RST[5:2]);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i && lo_ready_i));
  assert_done_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/rxcal_seq_tb.sv
module rxcal_seq_tb;
  localparam int MODE_CYC = 20, CAL_CYC = 30, SETTLE_CYC = 25, AGND_CYC = 40;
  localparam int LAT = 2;
  localparam int NEXP = 9;
  // {addr[5:0], data[7:0]}: regulator run, direct run without reset, direct run after reset
  localparam logic [13:0] EXP_WR [NEXP] = '{14'h186, 14'h106, 14'h1C6, 14'h1C7, 14'h205,
                                            14'h1C7, 14'h205, 14'h187, 14'h205};

  logic clk = 0, rst_n = 0;
  logic start = 0, lo_ready = 0, ldo_path = 0, ack = 0;
  logic wr_valid, busy, done;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, fails = 0;
  int cyc = 0, vcnt = 0, nlog = 0, ndone = 0, last_done = 0, hold_err = 0;
  logic [13:0] log_wr [32];
  int          log_t  [32];
  logic [13:0] first_seen;

  always #5 clk = ~clk;

  rxcal_seq #(.MODE_CYC(MODE_CYC), .CAL_CYC(CAL_CYC), .SETTLE_CYC(SETTLE_CYC),
              .AGND_CYC(AGND_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lo_ready_i(lo_ready),
    .ldo_path_i(ldo_path), .wr_ack_i(ack), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy), .done_o(done));

  // serial master model: acks LAT negedges after a request is first counted
  always @(negedge clk) begin
    cyc++;
    if (done) begin ndone++; last_done = cyc; end
    if (!rst_n) begin
      ack = 0; vcnt = 0;
    end else if (ack) begin
      ack = 0; vcnt = 0;
    end else if (wr_valid) begin
      if (vcnt == 0) first_seen = {wr_addr, wr_data};
      else if (first_seen != {wr_addr, wr_data}) hold_err++;
      if (vcnt == LAT) begin
        ack = 1;
        if (nlog < 32) begin log_wr[nlog] = {wr_addr, wr_data}; log_t[nlog] = cyc; end
        nlog++;
      end else vcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic run_seq(input logic path, input bit poke_busy);
    int d0;
    d0 = ndone;
    @(negedge clk);
    ldo_path = path; lo_ready = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (ndone == d0) @(negedge clk);
    chk(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nd;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !done, "R1 outputs in reset", {wr_valid, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !done, "R1 outputs after reset", {wr_valid, busy, done}, 0);

    // R2: start without LO ready ignored
    lo_ready = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(busy == 0, "R2 start gated by lo_ready busy", int'(busy), 0);
    chk(nlog == 0, "R2 start gated by lo_ready writes", nlog, 0);

    // regulator path with a start poked while busy (R2, R3)
    run_seq(1'b1, 1'b1);
    chk(nlog == 5, "R2 R3 regulator write count", nlog, 5);
    chk(ndone == 1, "R2 single done", ndone, 1);
    chk(log_t[1] - log_t[0] == LAT + 2, "R6 back-to-back gap", log_t[1] - log_t[0], LAT + 2);
    chk(log_t[2] - log_t[1] == LAT + 2, "R6 back-to-back gap 2", log_t[2] - log_t[1], LAT + 2);
    chk(log_t[3] - log_t[2] == AGND_CYC + LAT + 1, "R7 agnd wait",
        log_t[3] - log_t[2], AGND_CYC + LAT + 1);
    chk(log_t[4] - log_t[3] == MODE_CYC + LAT + 1, "R8 mode wait reg path",
        log_t[4] - log_t[3], MODE_CYC + LAT + 1);
    chk(last_done - log_t[4] == CAL_CYC + SETTLE_CYC + 1, "R9 cal+settle wait",
        last_done - log_t[4], CAL_CYC + SETTLE_CYC + 1);

    // direct path without reset: shadow keeps regulator bits (R5)
    run_seq(1'b0, 1'b0);
    chk(nlog == 7, "R4 R5 direct write count", nlog, 7);
    chk(log_t[6] - log_t[5] == MODE_CYC + LAT + 1, "R8 mode wait direct",
        log_t[6] - log_t[5], MODE_CYC + LAT + 1);
    chk(last_done - log_t[6] == CAL_CYC + SETTLE_CYC + 1, "R9 done direct",
        last_done - log_t[6], CAL_CYC + SETTLE_CYC + 1);

    // direct path from reset (R4)
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    run_seq(1'b0, 1'b0);
    chk(nlog == 9, "R4 direct from reset count", nlog, 9);

    // walk the expected write table (R3 R4 R5)
    for (int i = 0; i < NEXP; i++)
      chk(log_wr[i] == EXP_WR[i], (i < 5) ? "R3 write" : (i < 7) ? "R5 write" : "R4 write",
          int'(log_wr[i]), int'(EXP_WR[i]));
    chk(hold_err == 0, "R6 addr/data stable until ack", hold_err, 0);

    // reset mid-sequence (R1)
    nd = ndone;
    @(negedge clk);
    ldo_path = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (12) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!wr_valid && !busy && !done, "R1 reset mid-run", {wr_valid, busy, done}, 0);
    rst_n = 1;
    repeat (CAL_CYC + SETTLE_CYC + AGND_CYC) @(negedge clk);
    chk(ndone == nd && !busy, "R1 no resume after reset", ndone, nd);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule